// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier with Banked Multipliers

This block computes S = A·B·R⁻¹ mod N for operands of M words of K bits each, where R = 2^(K·M). Each of the M iterations takes one A word. A combinational quotient unit forms q_i. Several multiplier banks then sweep the B and N words in ascending order and produce the running products q·N + S and a·B one word per cycle. Each bank keeps a contiguous slice of the B and N words in its own local memory. The upper halves of the two running products are carried from word to word, and so from bank to bank. A single-bit-carry adder element merges the two low halves. The lowest merged word is dropped, which divides by 2^K. A second adder element at the top forms the most significant word from the two outgoing upper carries.

A host pulses `start` together with the inverse constant N' = −N⁻¹ mod 2^K. It then streams M load beats, each beat carrying one word of A, B and N. When the M iterations are done, the block presents the M result words one per cycle. The host must keep A, B < 2N and 4N < R. Under those limits the result needs no final subtraction. The block does not compute N', convert to or from the Montgomery domain, or run exponentiation.

Top module: `mm_parmont`

## Requirements
- R1: After a synchronous reset, `busy`, `res_valid` and `res_last` are 0.
- R2: A `start` pulse while idle raises `busy` in the next cycle and captures `nprime`. The next M cycles with `ld_valid` high load word j of A, B and N (j = 0 first, the least significant word) from `ld_a`, `ld_b` and `ld_n`.
- R3: The result equals the exact value of the recurrence S_0 = 0, q_i = ((S_i mod 2^K + a_i·b_0)·N') mod 2^K, S_(i+1) = (S_i + q_i·N + a_i·B)/2^K after M iterations. The result is congruent to A·B·R⁻¹ modulo N.
- R4: With A, B < 2N and 4N < R, the result is below 2N, and no intermediate value reaches R.
- R5: The result appears as M consecutive cycles with `res_valid` high. `res_idx` counts 0 to M−1 upward and tags the word's position, least significant first. `res_last` is high only on word M−1. `res_valid` is low in the cycle after the last word.
- R6: The first result word appears exactly M·(M+3)+1 clock edges after the edge that accepts the last load beat. Each iteration takes one quotient cycle plus M+2 sweep cycles.
- R7: `start` and `ld_valid` pulses after the last load beat and before the result is delivered have no effect on the result.
- R8: Load beats may be separated by idle cycles with `ld_valid` low. Such cycles load nothing.
- R9: Operations may run back to back. Each new operation starts from S_0 = 0, whatever the previous result was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| nprime | input | K | −N⁻¹ mod 2^K, sampled with start |
| ld_valid | input | 1 | Load beat valid |
| ld_a | input | K | Word of A for the current beat |
| ld_b | input | K | Word of B for the current beat |
| ld_n | input | K | Word of N for the current beat |
| busy | output | 1 | High from the load phase until the last result word |
| res_valid | output | 1 | Result word valid |
| res_word | output | K | Result word |
| res_idx | output | log2(M) | Position of the result word |
| res_last | output | 1 | Marks word M−1 |

## Verification
Random odd moduli below R/4 with operands below 2N exercise the normal path. Each result is compared exactly with the recurrence and also for congruence, so a wrong quotient shows up even when the residue class happens to match. Directed cases cover A = 0, B = 0, N = 1 and the largest legal modulus with A = B = 2N−1. Those cases separate lost carries on the top word from errors in the low words. Load beats with gaps, stray start and load pulses during computation, and operations issued back to back separate correct beat counting and S clearing from state that leaks between runs.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_QUOT,
    ST_SWEEP,
    ST_OUT
  } mm_state_e;
endpackage

// File: rtl/mm_quot.sv
module mm_quot #(
  parameter int K = 16
) (
  input  logic [K-1:0] s0,
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b0,
  input  logic [K-1:0] np,
  output logic [K-1:0] q
);
  logic [K-1:0] t;
  always_comb begin
    t = s0 + a_i * b0;   // mod 2^K by truncation
    q = t * np;
  end
endmodule

// File: rtl/mm_addel.sv
module mm_addel #(
  parameter int K = 16
) (
  input  logic [K-1:0] w,
  input  logic [K-1:0] u,
  input  logic         cin,
  output logic [K-1:0] s,
  output logic         cout
);
  logic [K:0] sum;
  always_comb begin
    sum  = {1'b0, w} + {1'b0, u} + {{K{1'b0}}, cin};
    s    = sum[K-1:0];
    cout = sum[K];
  end
endmodule

// File: rtl/mm_bank.sv
module mm_bank #(
  parameter int K   = 16,
  parameter int WPB = 4,
  localparam int AW = (WPB > 1) ? $clog2(WPB) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [AW-1:0]  wr_addr,
  input  logic [K-1:0]   wr_b,
  input  logic [K-1:0]   wr_n,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  input  logic [K-1:0]   q,
  input  logic [K-1:0]   a,
  output logic [2*K-1:0] prod_qn,
  output logic [2*K-1:0] prod_ab
);
  logic [K-1:0] b_mem [WPB];
  logic [K-1:0] n_mem [WPB];
  logic [K-1:0] b_rd, n_rd;
  logic         rd_v;

  // local slice memories: synchronous write, registered read
  always_ff @(posedge clk) begin
    if (we) begin
      b_mem[wr_addr] <= wr_b;
      n_mem[wr_addr] <= wr_n;
    end
    if (rd_en) begin
      b_rd <= b_mem[rd_addr];
      n_rd <= n_mem[rd_addr];
    end
  end

  // pipelined word multipliers: one product pair per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v    <= 1'b0;
      prod_qn <= '0;
      prod_ab <= '0;
    end else begin
      rd_v <= rd_en;
      if (rd_v) begin
        prod_qn <= {{K{1'b0}}, q} * {{K{1'b0}}, n_rd};
        prod_ab <= {{K{1'b0}}, a} * {{K{1'b0}}, b_rd};
      end
    end
  end

  AST_BANK_NO_RW: assert property (@(posedge clk) disable iff (rst)
    !(we && rd_en)); // R2
endmodule

// File: rtl/mm_parmont.sv
module mm_parmont
  import mm_pkg::*;
#(
  parameter int K     = 16,
  parameter int M     = 8,
  parameter int NBANK = 2,
  localparam int WPB  = M / NBANK,
  localparam int AW   = (WPB > 1) ? $clog2(WPB) : 1,
  localparam int IW   = (M > 1) ? $clog2(M) : 1,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CW   = $clog2(M + 2) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [K-1:0]  nprime,
  input  logic          ld_valid,
  input  logic [K-1:0]  ld_a,
  input  logic [K-1:0]  ld_b,
  input  logic [K-1:0]  ld_n,
  output logic          busy,
  output logic          res_valid,
  output logic [K-1:0]  res_word,
  output logic [IW-1:0] res_idx,
  output logic          res_last
);
  mm_state_e     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] iter;
  logic [K-1:0]  np_r, b0_r, q_r, q_comb;
  logic [K-1:0]  a_r [M];
  logic [K-1:0]  s_r [M];
  logic [K-1:0]  c1, c2;
  logic          cpe;

  // word / bank addressing
  logic [IW-1:0] word_idx;
  logic [BW-1:0] cur_bank;
  logic [AW-1:0] cur_addr;
  logic          issue, load_beat;
  assign word_idx  = cnt[IW-1:0];
  assign cur_bank  = BW'(int'(word_idx) / WPB);
  assign cur_addr  = AW'(int'(word_idx) % WPB);
  assign issue     = (state == ST_SWEEP) && (cnt < CW'(M));
  assign load_beat = (state == ST_LOAD) && ld_valid;
  assign busy      = (state != ST_IDLE);

  logic [NBANK-1:0] bank_we, bank_rd;
  logic [2*K-1:0]   pqn [NBANK];
  logic [2*K-1:0]   pab [NBANK];

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign bank_we[g] = load_beat && (cur_bank == BW'(g));
      assign bank_rd[g] = issue && (cur_bank == BW'(g));
      mm_bank #(.K(K), .WPB(WPB)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (bank_we[g]),
        .wr_addr (cur_addr),
        .wr_b    (ld_b),
        .wr_n    (ld_n),
        .rd_en   (bank_rd[g]),
        .rd_addr (cur_addr),
        .q       (q_r),
        .a       (a_r[iter]),
        .prod_qn (pqn[g]),
        .prod_ab (pab[g])
      );
    end
  endgenerate

  mm_quot #(.K(K)) u_quot (
    .s0  (s_r[0]),
    .a_i (a_r[iter]),
    .b0  (b0_r),
    .np  (np_r),
    .q   (q_comb)
  );

  // sweep pipeline: issue -> memory read -> product -> carry/add
  logic          p1_v, p2_v;
  logic [IW-1:0] p1_idx, p2_idx;
  logic [BW-1:0] p1_bank, p2_bank;
  logic [K-1:0]  p2_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_v <= 1'b0;  p2_v <= 1'b0;
      p1_idx <= '0;  p2_idx <= '0;
      p1_bank <= '0; p2_bank <= '0;
      p2_s <= '0;
    end else begin
      p1_v    <= issue;
      p1_idx  <= word_idx;
      p1_bank <= cur_bank;
      p2_v    <= p1_v;
      p2_idx  <= p1_idx;
      p2_bank <= p1_bank;
      p2_s    <= s_r[p1_idx];
    end
  end

  // running products with upper-half carries handed word to word
  logic [2*K-1:0] tw, tu;
  logic [K-1:0]   sum_lo, top_s;
  logic           sum_co, top_co;
  always_comb begin
    tw = pqn[p2_bank] + {{K{1'b0}}, p2_s} + {{K{1'b0}}, c1};
    tu = pab[p2_bank] + {{K{1'b0}}, c2};
  end

  mm_addel #(.K(K)) u_el_word (
    .w    (tw[K-1:0]),
    .u    (tu[K-1:0]),
    .cin  (cpe),
    .s    (sum_lo),
    .cout (sum_co)
  );

  mm_addel #(.K(K)) u_el_top (
    .w    (tw[2*K-1:K]),
    .u    (tu[2*K-1:K]),
    .cin  (sum_co),
    .s    (top_s),
    .cout (top_co)
  );

  // operand A store
  always_ff @(posedge clk) begin
    if (load_beat) a_r[word_idx] <= ld_a;
  end

  // S store: cleared on start, word j-1 written from element j
  always_ff @(posedge clk) begin
    if (rst || (state == ST_IDLE && start)) begin
      for (int j = 0; j < M; j++) s_r[j] <= '0;
    end else if (p2_v) begin
      if (p2_idx != '0) s_r[p2_idx - 1'b1] <= sum_lo;
      if (p2_idx == IW'(M - 1)) s_r[M-1] <= top_s;
    end
  end

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      iter      <= '0;
      np_r      <= '0;
      b0_r      <= '0;
      q_r       <= '0;
      c1        <= '0;
      c2        <= '0;
      cpe       <= 1'b0;
      res_valid <= 1'b0;
      res_last  <= 1'b0;
      res_word  <= '0;
      res_idx   <= '0;
    end else begin
      res_valid <= 1'b0;
      res_last  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_LOAD;
            cnt   <= '0;
            np_r  <= nprime;
          end
        end
        ST_LOAD: begin
          if (ld_valid) begin
            if (cnt == '0) b0_r <= ld_b;
            if (cnt == CW'(M - 1)) begin
              state <= ST_QUOT;
              cnt   <= '0;
              iter  <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_QUOT: begin
          q_r   <= q_comb;
          c1    <= '0;
          c2    <= '0;
          cpe   <= 1'b0;
          cnt   <= '0;
          state <= ST_SWEEP;
        end
        ST_SWEEP: begin
          if (p2_v) begin
            c1  <= tw[2*K-1:K];
            c2  <= tu[2*K-1:K];
            cpe <= sum_co;
          end
          if (cnt == CW'(M + 1)) begin
            cnt <= '0;
            if (iter == IW'(M - 1)) begin
              state <= ST_OUT;
            end else begin
              iter  <= iter + 1'b1;
              state <= ST_QUOT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OUT: begin
          res_valid <= 1'b1;
          res_word  <= s_r[word_idx];
          res_idx   <= word_idx;
          res_last  <= (cnt == CW'(M - 1));
          if (cnt == CW'(M - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_BANK_READ: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_rd)); // R3
  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_we) <= 1); // R2
  AST_TOP_FITS: assert property (@(posedge clk) disable iff (rst)
    (p2_v && p2_idx == IW'(M - 1)) |-> !top_co); // R4
  AST_RES_ORDER: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_last) |=> (res_valid && res_idx == IW'($past(res_idx) + 1'b1))); // R5
  AST_RES_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> (res_idx == '0)); // R5
  AST_RES_END: assert property (@(posedge clk) disable iff (rst)
    res_last |=> !res_valid); // R5
endmodule

// File: tb/tb_mm_parmont.sv
`timescale 1ns/1ps
module tb_mm_parmont;
  localparam int K     = 16;
  localparam int M     = 8;
  localparam int NB    = 2;
  localparam int IW    = $clog2(M);
  localparam int NBITS = K * M;
  localparam int EW    = NBITS + K + 4;
  localparam int DW    = 2 * NBITS + 2;
  localparam int LAT   = M * (M + 3) + 1;

  typedef logic [NBITS-1:0] wide_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [K-1:0]  nprime = '0;
  logic          ld_valid = 1'b0;
  logic [K-1:0]  ld_a = '0, ld_b = '0, ld_n = '0;
  logic          busy, res_valid, res_last;
  logic [K-1:0]  res_word;
  logic [IW-1:0] res_idx;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mm_parmont #(.K(K), .M(M), .NBANK(NB)) dut (
    .clk(clk), .rst(rst), .start(start), .nprime(nprime),
    .ld_valid(ld_valid), .ld_a(ld_a), .ld_b(ld_b), .ld_n(ld_n),
    .busy(busy), .res_valid(res_valid), .res_word(res_word),
    .res_idx(res_idx), .res_last(res_last)
  );

  task automatic check(input bit ok, input string req, input wide_t got, input wide_t exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [K-1:0] calc_np(input wide_t n);
    logic [K-1:0] n0, x, two;
    n0 = n[K-1:0];
    x = n0;
    two = 2;
    for (int i = 0; i < 6; i++) x = x * (two - n0 * x);
    return -x;
  endfunction

  function automatic wide_t ref_mont(input wide_t a, input wide_t b, input wide_t n, input logic [K-1:0] np);
    logic [EW-1:0] s, qw, aw, nw, bw;
    logic [K-1:0]  ai, t0, q;
    s = '0;
    nw = EW'(n);
    bw = EW'(b);
    for (int i = 0; i < M; i++) begin
      ai = a[i*K +: K];
      t0 = s[K-1:0] + ai * b[K-1:0];
      q  = t0 * np;
      qw = EW'(q);
      aw = EW'(ai);
      s  = (s + qw * nw + aw * bw) >> K;
    end
    return s[NBITS-1:0];
  endfunction

  function automatic wide_t rand_wide();
    wide_t v;
    v = '0;
    for (int i = 0; i < (NBITS + 31) / 32; i++) v = (v << 32) | wide_t'($urandom);
    return v;
  endfunction

  task automatic run_op(input wide_t a, input wide_t b, input wide_t n,
                        input bit gaps, input bit disturb, input string tag);
    wide_t got, exp;
    logic [DW-1:0] lhs, rhs;
    int k;
    bit ord_ok;
    exp = ref_mont(a, b, n, calc_np(n));
    @(negedge clk);
    start = 1'b1;
    nprime = calc_np(n);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", wide_t'(busy), wide_t'(1));
    for (int j = 0; j < M; j++) begin
      if (gaps && (j % 2 == 1)) begin
        ld_valid = 1'b0;
        ld_a = 16'hdead; ld_b = 16'hbeef; ld_n = 16'h1234;   // R8 junk on idle beat
        @(negedge clk);
      end
      ld_valid = 1'b1;
      ld_a = a[j*K +: K];
      ld_b = b[j*K +: K];
      ld_n = n[j*K +: K];
      @(negedge clk);
    end
    ld_valid = 1'b0;
    k = 0;
    while (!res_valid && k < 4 * LAT) begin
      start    = disturb && (k == 5);
      ld_valid = disturb && (k == 5 || k == 40);    // R7 stray pulses
      ld_a = '1; ld_b = '1; ld_n = '1;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    ld_valid = 1'b0;
    check(k == LAT, "R6 latency", wide_t'(k), wide_t'(LAT));
    ord_ok = 1'b1;
    got = '0;
    for (int w = 0; w < M; w++) begin
      ord_ok &= res_valid && (res_idx == IW'(w)) && (res_last == (w == M - 1));
      got[w*K +: K] = res_word;
      @(negedge clk);
    end
    ord_ok &= !res_valid && !busy;
    check(ord_ok, "R5 output order", wide_t'(ord_ok), wide_t'(1));
    check(got == exp, {"R3 exact ", tag}, got, exp);
    lhs = (DW'(got) << NBITS) % DW'(n);
    rhs = (DW'(a) * DW'(b)) % DW'(n);
    check(lhs == rhs, {"R3 congruence ", tag}, wide_t'(lhs), wide_t'(rhs));
    check(DW'(got) < (DW'(n) << 1), {"R4 below 2N ", tag}, got, n << 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wide_t n, a, b, nmax;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !res_valid && !res_last, "R1 reset outputs",
          wide_t'({busy, res_valid, res_last}), '0);

    nmax = (wide_t'(1) << (NBITS - 2)) - 1;
    // directed corner cases
    run_op('0, nmax - 5, nmax, 1'b0, 1'b0, "A zero");
    run_op(nmax - 7, '0, nmax, 1'b0, 1'b0, "B zero");
    run_op(wide_t'(1), wide_t'(1), wide_t'(1), 1'b0, 1'b0, "N one");
    run_op((nmax << 1) - 1, (nmax << 1) - 1, nmax, 1'b0, 1'b0, "R4 max operands");
    // random operands, some with load gaps (R8) and stray pulses (R7), back to back (R9)
    for (int t = 0; t < 10; t++) begin
      n = (rand_wide() >> 2) | wide_t'(1);
      a = rand_wide() % (n << 1);
      b = rand_wide() % (n << 1);
      run_op(a, b, n, (t % 3) == 1, (t % 3) == 2,
             (t % 3) == 1 ? "R8 gaps" : ((t % 3) == 2 ? "R7 stray" : "R9 random"));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule